// File: doc/BRIEF.md
# DMA Task Completion Interrupt Collector

This block gathers completion events from sixteen DMA tasks into a sticky pending register and pairs it with a per-task mask register. Every unmasked pending bit feeds one registered request line, which is meant to drive peripheral interrupt input 0 of the system interrupt controller. A service routine that receives that request reads the status word to learn which task to serve. The status word holds the index of the lowest-numbered pending task and a flag that says whether any task is pending at all.

Software reaches the block through a simple register port with one write strobe, a two-bit word address and write data, and it reads through combinational read data. At start-up software sets every mask bit and clears every pending bit by writing all ones to both registers. After that it clears a pending bit by writing a one to it.

Top module: `dma_task_irq_collector`

## Requirements
- R1: A high level on `task_evt[n]` at a rising clock edge sets pending bit n. The bit then stays set until software clears it, and it reads back as bit n of word address 0.
- R2: A write to word address 0 clears every pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged, so writing all zeros changes nothing.
- R3: Word address 1 is the mask register, and bit n belongs to task n. A 1 disables the task's contribution to the request and a 0 enables it. A write stores the full word, a read returns it, and reset sets every mask bit.
- R4: `irq_out` is a register. In each cycle it shows the OR over all tasks of (pending AND NOT mask), taken from the register state one clock earlier.
- R5: `svc_idx` gives the lowest-numbered pending bit, whatever the mask holds, and `svc_valid` is high whenever any pending bit is set. When nothing is pending, `svc_idx` is 0 and `svc_valid` is low.
- R6: If a task event and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R7: A read of word address 2 returns `svc_idx` in bits 3:0 and `svc_valid` in bit 4, with zeros in all other bits. A read of word address 3 returns zero.
- R8: After reset all pending bits are 0, every mask bit is 1 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| task_evt | input | 16 | Completion event from each task, sampled at the clock edge |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word address: 0 pending, 1 mask, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered aggregated request |
| svc_idx | output | 4 | Lowest pending task index |
| svc_valid | output | 1 | Any task pending |

## Verification
The bench targets the collision between an event and a clear of the same bit. A design that lets the clear win would lose that completion for good. The bench also writes zeros to the pending register, which catches a block that treats the register as plain write data and wipes it. It checks that the lowest pending index is chosen and stays independent of the mask, since a reversed encoder would report bit 15 first. Finally it samples the request one cycle after the pending state changes, and a request built without the output register would already be high at that point.

// File: rtl/dma_task_irq_collector.sv
module dma_task_irq_collector #(
  parameter int NTASK = 16,
  parameter int IDXW  = $clog2(NTASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTASK-1:0] task_evt,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NTASK-1:0] bus_wdata,
  output logic [NTASK-1:0] bus_rdata,
  output logic             irq_out,
  output logic [IDXW-1:0]  svc_idx,
  output logic             svc_valid
);

  logic [NTASK-1:0] pend_q, mask_q;
  logic [NTASK-1:0] clr_vec;

  assign clr_vec = (bus_wr && bus_addr == 2'd0) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '1;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~clr_vec) | task_evt;
      if (bus_wr && bus_addr == 2'd1) mask_q <= bus_wdata;
      irq_out <= |(pend_q & ~mask_q);
    end
  end

  always_comb begin
    svc_idx = '0;
    for (int i = NTASK - 1; i >= 0; i--)
      if (pend_q[i]) svc_idx = IDXW'(i);
  end

  assign svc_valid = |pend_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = pend_q;
      2'd1: bus_rdata = mask_q;
      2'd2: bus_rdata = NTASK'({svc_valid, svc_idx});
      default: bus_rdata = '0;
    endcase
  end

endmodule

module dma_task_irq_collector_chk #(
  parameter int NTASK = 16,
  parameter int IDXW  = $clog2(NTASK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NTASK-1:0] task_evt,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [NTASK-1:0] bus_wdata,
  input logic [NTASK-1:0] pend_q,
  input logic [NTASK-1:0] mask_q,
  input logic             irq_out,
  input logic [IDXW-1:0]  svc_idx,
  input logic             svc_valid
);

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> ((pend_q & $past(bus_wdata) & ~$past(task_evt)) == '0));

  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|task_evt) |=> ((pend_q & $past(task_evt)) == $past(task_evt)));

  // R1
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == 2'd0) && task_evt == '0) |=> $stable(pend_q));

  // R4
  irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_out == $past(|(pend_q & ~mask_q))));

  // R5
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_valid |-> (svc_idx == '0));

  // R5
  idx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> pend_q[svc_idx]);

endmodule

bind dma_task_irq_collector dma_task_irq_collector_chk #(.NTASK(NTASK), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_evt(task_evt), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
  .mask_q(mask_q), .irq_out(irq_out), .svc_idx(svc_idx), .svc_valid(svc_valid)
);

// File: tb/dma_task_irq_collector_bench.sv
`timescale 1ns/1ps
module dma_task_irq_collector_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] task_evt = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_out;
  logic [3:0]  svc_idx;
  logic        svc_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_task_irq_collector u_dma_task_irq_collector (
    .clk(clk), .rst_n(rst_n), .task_evt(task_evt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .svc_idx(svc_idx), .svc_valid(svc_valid)
  );

  // {wr, addr, wdata, evt, exp_pend, exp_mask, exp_irq, exp_idx, exp_valid}
  localparam int NV = 12;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 4'd0,  1'b0},
    {1'b0, 2'd0, 16'h0000, 16'h0010, 16'h0010, 16'hFFFF, 1'b0, 4'd4,  1'b1},
    {1'b1, 2'd1, 16'hFFEF, 16'h0000, 16'h0010, 16'hFFEF, 1'b1, 4'd4,  1'b1},
    {1'b0, 2'd0, 16'h0000, 16'h8001, 16'h8011, 16'hFFEF, 1'b1, 4'd0,  1'b1},
    {1'b1, 2'd0, 16'h0001, 16'h0000, 16'h8010, 16'hFFEF, 1'b1, 4'd4,  1'b1},
    {1'b1, 2'd0, 16'h0010, 16'h0010, 16'h8010, 16'hFFEF, 1'b1, 4'd4,  1'b1},
    {1'b1, 2'd0, 16'h0000, 16'h0000, 16'h8010, 16'hFFEF, 1'b1, 4'd4,  1'b1},
    {1'b1, 2'd0, 16'h0010, 16'h0000, 16'h8000, 16'hFFEF, 1'b0, 4'd15, 1'b1},
    {1'b1, 2'd1, 16'h7FFF, 16'h0000, 16'h8000, 16'h7FFF, 1'b1, 4'd15, 1'b1},
    {1'b1, 2'd0, 16'hFFFF, 16'h0000, 16'h0000, 16'h7FFF, 1'b0, 4'd0,  1'b0},
    {1'b1, 2'd1, 16'hFFFF, 16'h0400, 16'h0400, 16'hFFFF, 1'b0, 4'd10, 1'b1},
    {1'b1, 2'd0, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 4'd0,  1'b0}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_wr = 1'b0; bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] wd, input logic [15:0] ev);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; task_evt = ev;
    @(negedge clk);
    bus_wr = 1'b0; task_evt = '0; bus_wdata = '0;
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected < 5000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "irq", {15'd0, irq_out}, 16'd0);
    rd(2'd0, d); chk("R8", "pend", d, 16'h0000);
    rd(2'd1, d); chk("R3", "mask reset", d, 16'hFFFF);
    rd(2'd2, d); chk("R7", "status", d, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      step(v[72], v[71:70], v[69:54], v[53:38]);
      @(negedge clk);
      rd(2'd0, d); chk("R1/R2/R6", $sformatf("vec%0d pend", i), d, v[37:22]);
      rd(2'd1, d); chk("R3", $sformatf("vec%0d mask", i), d, v[21:6]);
      chk("R4", $sformatf("vec%0d irq", i), {15'd0, irq_out}, {15'd0, v[5]});
      chk("R5", $sformatf("vec%0d idx", i), {12'd0, svc_idx}, {12'd0, v[4:1]});
      chk("R5", $sformatf("vec%0d valid", i), {15'd0, svc_valid}, {15'd0, v[0]});
      rd(2'd2, d); chk("R7", $sformatf("vec%0d status", i), d, {11'd0, v[0], v[4:1]});
    end

    // R4 latency: request lags pending by one cycle
    step(1'b1, 2'd1, 16'hFFF7, 16'h0000);
    @(negedge clk);
    bus_addr = 2'd0; task_evt = 16'h0008;
    @(negedge clk);
    task_evt = '0;
    chk("R4", "irq before register", {15'd0, irq_out}, 16'd0);
    chk("R1", "pend bit3", {15'd0, svc_valid}, 16'd1);
    @(negedge clk);
    chk("R4", "irq after register", {15'd0, irq_out}, 16'd1);
    rd(2'd3, d); chk("R7", "addr3 zero", d, 16'h0000);

    done = 1'b1;
    finish_up();
  end

endmodule